// File: doc/BRIEF.md
# Diagnostic Magnetic Latch Output Controller

This block is the digital core of a three-level magnetic latch sensor. It watches a stream of signed field samples, each marked by a valid strobe. It keeps a latched on/off state with hysteresis that is symmetric around zero: the release threshold is the negative of the operate threshold. It converts that state into a 2-bit output-level code, and the selected output polarity sets which level stands for "on".

A third code, FAULT, tells the host that the output is not trustworthy. FAULT is shown from reset until a power-on delay has elapsed. It is also shown as soon as any subsystem fault flag is raised. While faulted, the block looks at the flags again only at the end of each retry interval. It returns to normal switching at the first retry that finds all flags clear.

Top module: `diag_latch_out`

## Requirements
- R1: A valid sample strictly greater than the operate threshold sets the latched state to on; a sample equal to the threshold does not.
- R2: A valid sample strictly less than the negative of the operate threshold clears the latched state to off; a sample equal to that value does not.
- R3: A valid sample whose value lies between the negative and positive operate threshold, both ends included, leaves the latched state unchanged.
- R4: The operate threshold is chosen by `thrSel`, in units of 0.1 G: code 0 gives 220, code 1 gives 500, and codes 2 and 3 give 1500.
- R5: Output codes are LOW = 2'b01, HIGH = 2'b10 and FAULT = 2'b11. With `invertPol` = 0, on maps to LOW and off maps to HIGH. With `invertPol` = 1 the mapping is swapped, and a change of `invertPol` takes effect in the same cycle.
- R6: `outCode` is FAULT while reset is asserted and for the first POR_CYCLES-1 rising edges after reset is released. Normal output starts after edge POR_CYCLES.
- R7: The latched state comes out of reset as off. A field held inside the hysteresis band through power-up therefore gives the off level of the selected polarity: HIGH when standard, LOW when inverted.
- R8: During normal operation, any nonzero bit of `faultFlags` at a rising edge makes `outCode` FAULT right after that edge.
- R9: Once faulted, the flags are examined only at every RETRY_CYCLES-th edge after fault entry. If any flag is still set at that edge, FAULT holds for a further interval, and this repeats without end.
- R10: If all flags are clear at a retry edge, normal output resumes right after that edge and reflects the current latched state.
- R11: When `sampleValid` is low, `sampleField` has no effect on the latched state.
- R12: `outCode` never takes the value 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Field sample strobe |
| sampleField | input | FIELD_W | Signed field sample, 0.1 G units |
| faultFlags | input | NFLAG | Per-subsystem fault indications |
| thrSel | input | 2 | Operate threshold select |
| invertPol | input | 1 | Output polarity inversion |
| outCode | output | 2 | Output level code (LOW/HIGH/FAULT) |

## Verification
The bench builds the block with POR_CYCLES = 20 and RETRY_CYCLES = 50 in place of the microsecond-scale defaults. With these values the exact power-up release edge falls within a short run. So do two full retry windows: one in which the fault persists and one in which it clears 40 cycles before the next retry. The bench can therefore check that recovery occurs exactly on the retry edge and not earlier. The threshold values are kept at their defaults, so every selector code is tested on both sides of its boundary.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [1:0] {
    CODE_LOW   = 2'b01,
    CODE_HIGH  = 2'b10,
    CODE_FAULT = 2'b11
  } outcode_e;

  typedef enum logic [1:0] {
    PH_BOOT  = 2'd0,
    PH_RUN   = 2'd1,
    PH_FAULT = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic runEn;
  } ctrl_s;
endpackage

// File: rtl/dl_datapath.sv
module dl_datapath
  import dl_pkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int OP_LO   = 220,
  parameter int OP_MID  = 500,
  parameter int OP_HI   = 1500
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_s                     ctrl,
  input  logic                      sampleValid,
  input  logic signed [FIELD_W-1:0] sampleField,
  input  logic [1:0]                thrSel,
  input  logic                      invertPol,
  output logic [1:0]                outCode
);
  localparam int EXT_W = FIELD_W + 1;
  localparam logic signed [EXT_W-1:0] OP_LO_V  = EXT_W'(OP_LO);
  localparam logic signed [EXT_W-1:0] OP_MID_V = EXT_W'(OP_MID);
  localparam logic signed [EXT_W-1:0] OP_HI_V  = EXT_W'(OP_HI);

  logic signed [EXT_W-1:0] opPos;
  logic signed [EXT_W-1:0] opNeg;
  logic signed [EXT_W-1:0] fieldExt;
  logic aboveOp;
  logic belowRel;
  logic latchOn;

  always_comb begin
    case (thrSel)
      2'd0:    opPos = OP_LO_V;
      2'd1:    opPos = OP_MID_V;
      default: opPos = OP_HI_V;
    endcase
    opNeg    = -opPos;
    fieldExt = {sampleField[FIELD_W-1], sampleField};
    aboveOp  = fieldExt > opPos;
    belowRel = fieldExt < opNeg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchOn <= 1'b0;
    end else if (sampleValid) begin
      if (aboveOp) begin
        latchOn <= 1'b1;
      end else if (belowRel) begin
        latchOn <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!ctrl.runEn) begin
      outCode = CODE_FAULT;
    end else if (latchOn ^ invertPol) begin
      outCode = CODE_LOW;
    end else begin
      outCode = CODE_HIGH;
    end
  end
endmodule

// File: rtl/dl_control.sv
module dl_control
  import dl_pkg::*;
#(
  parameter int NFLAG        = 4,
  parameter int POR_CYCLES   = 7500,
  parameter int RETRY_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NFLAG-1:0] faultFlags,
  output ctrl_s            ctrl
);
  localparam int MAX_CNT = (POR_CYCLES > RETRY_CYCLES) ? POR_CYCLES : RETRY_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] RETRY_LAST = CNT_W'(RETRY_CYCLES - 1);

  phase_e phase;
  logic [CNT_W-1:0] cnt;
  logic anyFault;

  assign anyFault = |faultFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_BOOT;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_BOOT: begin
          if (cnt == POR_LAST) begin
            cnt   <= '0;
            phase <= anyFault ? PH_FAULT : PH_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RUN: begin
          cnt <= '0;
          if (anyFault) begin
            phase <= PH_FAULT;
          end
        end
        PH_FAULT: begin
          if (cnt == RETRY_LAST) begin
            cnt <= '0;
            if (!anyFault) begin
              phase <= PH_RUN;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_FAULT;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    ctrl.runEn = (phase == PH_RUN);
  end
endmodule

// File: rtl/diag_latch_out.sv
module diag_latch_out
  import dl_pkg::*;
#(
  parameter int FIELD_W      = 16,
  parameter int NFLAG        = 4,
  parameter int POR_CYCLES   = 7500,
  parameter int RETRY_CYCLES = 100000,
  parameter int OP_LO        = 220,
  parameter int OP_MID       = 500,
  parameter int OP_HI        = 1500
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  input  logic signed [FIELD_W-1:0] sampleField,
  input  logic [NFLAG-1:0]          faultFlags,
  input  logic [1:0]                thrSel,
  input  logic                      invertPol,
  output logic [1:0]                outCode
);
  ctrl_s ctrl;

  dl_control #(
    .NFLAG(NFLAG),
    .POR_CYCLES(POR_CYCLES),
    .RETRY_CYCLES(RETRY_CYCLES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .faultFlags(faultFlags),
    .ctrl(ctrl)
  );

  dl_datapath #(
    .FIELD_W(FIELD_W),
    .OP_LO(OP_LO),
    .OP_MID(OP_MID),
    .OP_HI(OP_HI)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .ctrl(ctrl),
    .sampleValid(sampleValid),
    .sampleField(sampleField),
    .thrSel(thrSel),
    .invertPol(invertPol),
    .outCode(outCode)
  );
endmodule

// File: rtl/dl_checker.sv
module dl_checker #(
  parameter int FIELD_W    = 16,
  parameter int NFLAG      = 4,
  parameter int POR_CYCLES = 7500,
  parameter int OP_LO      = 220,
  parameter int OP_MID     = 500,
  parameter int OP_HI      = 1500
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      sampleValid,
  input logic signed [FIELD_W-1:0] sampleField,
  input logic [NFLAG-1:0]          faultFlags,
  input logic [1:0]                thrSel,
  input logic                      invertPol,
  input logic [1:0]                outCode
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] POR_V = CW'(POR_CYCLES);
  localparam logic [1:0] C_LOW = 2'b01, C_HIGH = 2'b10, C_FLT = 2'b11;

  logic [CW-1:0] edgesSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgesSeen <= '0;
    else if (edgesSeen != POR_V) edgesSeen <= edgesSeen + 1'b1;
  end

  int opNow;
  int fieldInt;
  always_comb begin
    opNow = (thrSel == 2'd0) ? OP_LO : (thrSel == 2'd1) ? OP_MID : OP_HI;
    fieldInt = int'(sampleField);
  end

  // R12: unused code never driven
  p_code_legal_r12: assert property (@(posedge clk) disable iff (!rstN)
    outCode != 2'b00);

  // R6: power-up window shows FAULT
  p_boot_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (edgesSeen < POR_V) |-> (outCode == C_FLT));

  // R8: flag in normal operation forces FAULT next cycle
  p_fault_react_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outCode != C_FLT && faultFlags != '0) |=> (outCode == C_FLT));

  // R1: field above operate point gives on level
  p_set_on_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outCode != C_FLT && faultFlags == '0 && sampleValid && fieldInt > opNow)
    |=> (invertPol != $past(invertPol)) ||
        (outCode == ($past(invertPol) ? C_HIGH : C_LOW)));

  // R3: field inside band holds the output
  p_band_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outCode != C_FLT && faultFlags == '0 && sampleValid &&
     fieldInt <= opNow && fieldInt >= -opNow)
    |=> (invertPol != $past(invertPol)) || (outCode == $past(outCode)));

  // R11: invalid samples ignored
  p_invalid_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outCode != C_FLT && faultFlags == '0 && !sampleValid)
    |=> (invertPol != $past(invertPol)) || (outCode == $past(outCode)));
endmodule

bind diag_latch_out dl_checker #(
  .FIELD_W(FIELD_W),
  .NFLAG(NFLAG),
  .POR_CYCLES(POR_CYCLES),
  .OP_LO(OP_LO),
  .OP_MID(OP_MID),
  .OP_HI(OP_HI)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .sampleValid(sampleValid),
  .sampleField(sampleField),
  .faultFlags(faultFlags),
  .thrSel(thrSel),
  .invertPol(invertPol),
  .outCode(outCode)
);

// File: tb/tb_diag_latch_out.sv
`timescale 1ns/1ps
module tb_diag_latch_out;
  localparam int POR = 20;
  localparam int RETRY = 50;
  localparam logic [1:0] LOW = 2'b01, HIGH = 2'b10, FLT = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleField = '0;
  logic [3:0] faultFlags = '0;
  logic [1:0] thrSel = 2'd0;
  logic invertPol = 1'b0;
  logic [1:0] outCode;

  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    logic [1:0] code;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  diag_latch_out #(
    .FIELD_W(16), .NFLAG(4), .POR_CYCLES(POR), .RETRY_CYCLES(RETRY)
  ) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleField(sampleField),
    .faultFlags(faultFlags), .thrSel(thrSel), .invertPol(invertPol), .outCode(outCode)
  );

  task automatic checkNow(input logic [1:0] exp, input string tag);
    nChecks++;
    if (outCode !== exp || outCode === 2'b00) begin
      nFail++;
      $display("FAIL %s: outCode=%b expected=%b at %0t", tag, outCode, exp, $time);
    end
  endtask

  // monitor: compares one expected item a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checkNow(e.code, e.tag);
      end
    end
  end

  // driver: called at a falling edge, returns at the next falling edge
  task automatic step(input logic v, input logic signed [15:0] f, input logic [3:0] fl,
                      input logic doChk, input logic [1:0] code, input string tag);
    exp_t e;
    sampleValid = v;
    sampleField = f;
    faultFlags  = fl;
    if (doChk) begin
      e.code = code;
      e.tag  = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: outCode=%b expected=run end", outCode);
    finishRun();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    checkNow(FLT, "R6 in reset");
    rstN = 1'b1;
    // R6 / R7: power-up, field in band
    for (int i = 1; i < POR; i++) step(1, 16'sd100, 4'b0, 1, FLT, "R6");
    step(1, 16'sd100, 4'b0, 1, HIGH, "R7 standard");

    step(1, 16'sd221, 4'b0, 1, LOW, "R1");
    step(1, 16'sd220, 4'b0, 1, LOW, "R3 equal op");
    step(1, -16'sd220, 4'b0, 1, LOW, "R2 equal release");
    step(1, -16'sd221, 4'b0, 1, HIGH, "R2");
    step(1, 16'sd220, 4'b0, 1, HIGH, "R3");
    step(0, 16'sd2000, 4'b0, 1, HIGH, "R11");
    step(0, 16'sd2000, 4'b0, 1, HIGH, "R11");

    thrSel = 2'd2;
    step(1, 16'sd1000, 4'b0, 1, HIGH, "R4 sel2 below");
    step(1, 16'sd1500, 4'b0, 1, HIGH, "R4 sel2 equal");
    step(1, 16'sd1501, 4'b0, 1, LOW, "R4 sel2 above");
    thrSel = 2'd1;
    step(1, -16'sd500, 4'b0, 1, LOW, "R4 sel1 equal");
    step(1, -16'sd501, 4'b0, 1, HIGH, "R4 sel1 below");
    thrSel = 2'd3;
    step(1, 16'sd1499, 4'b0, 1, HIGH, "R4 sel3 below");
    step(1, 16'sd1501, 4'b0, 1, LOW, "R4 sel3 above");

    invertPol = 1'b1;
    step(1, 16'sd0, 4'b0, 1, HIGH, "R5 inverted on");
    step(1, -16'sd1600, 4'b0, 1, LOW, "R5 inverted off");
    invertPol = 1'b0;
    step(1, 16'sd0, 4'b0, 1, HIGH, "R5 standard off");
    step(1, 16'sd1600, 4'b0, 1, LOW, "R5 standard on");

    // R8 then R9/R10: fault held 60 cycles, cleared, recovery at retry edge 100
    step(1, 16'sd1600, 4'b0100, 1, FLT, "R8");
    for (int i = 1; i <= 2 * RETRY; i++) begin
      if (i < 2 * RETRY)
        step(1, 16'sd1600, (i <= 60) ? 4'b0001 : 4'b0000, 1, FLT, "R9");
      else
        step(1, 16'sd1600, 4'b0000, 1, LOW, "R10");
    end
    step(1, 16'sd0, 4'b0, 1, LOW, "R10 normal switching");

    // R7 inverted: second power-up
    rstN = 1'b0;
    @(negedge clk);
    invertPol = 1'b1;
    rstN = 1'b1;
    for (int i = 1; i < POR; i++) step(1, -16'sd50, 4'b0, 0, FLT, "R6");
    step(1, -16'sd50, 4'b0, 1, LOW, "R7 inverted");
    step(1, -16'sd50, 4'b0, 1, LOW, "R12");
    @(negedge clk);
    finishRun();
  end
endmodule